// File: doc/BRIEF.md
# Interleaved-Bitplane Pixel Serializer

This block turns one fetched display byte into a run of coloured output positions. The byte is split into 8, 4 or 2 pixels according to a colour depth of 1, 2 or 4 bits per pixel. At depths above one, the bits of a pixel are spread across the byte rather than packed side by side. Each pixel index passes through a 16-entry palette to a 3-bit RGB value. Each pixel is then held on the output for a programmable number of cycles, so that narrow modes still cover the full line width.

A fetch unit pulses the load strobe with a byte while the serializer is idle. The depth and the hold factor are sampled in the same cycle. From the next cycle the output carries one colour per clock until the byte is used up, and then goes black until the next load. A blank-line input forces black and freezes the serializer in place for as long as it is high.

Top module: `pix_serializer`

## Requirements
- R1: After reset the serializer is idle and `rgb` is 0 (black).
- R2: A load strobe while idle captures `pixByte`, `depthSel` and `scaleSel`. From the next cycle `rgb` shows pixel 0, and the pixels follow in index order.
- R3: With `depthSel` = 1 the byte yields 8 pixels, and pixel n is bit 7−n (bit 7 first).
- R4: With `depthSel` = 2 the byte yields 4 pixels, and pixel n (0..3) has bit 7−n as index bit 1 and bit 3−n as index bit 0.
- R5: With `depthSel` = 4 the byte yields 2 pixels. Pixel 0 has index bits 3..0 taken from byte bits 7,5,3,1, and pixel 1 has them from byte bits 6,4,2,0.
- R6: Palette entry i holds colour i mod 8, so indices 8..15 repeat 0..7. `rgb` bit 0 is red, bit 1 is green and bit 2 is blue.
- R7: Each pixel stays on `rgb` for `scaleSel` consecutive unblanked cycles. A `scaleSel` of 0 acts as 1.
- R8: After the last pixel's final cycle the serializer is idle and `rgb` is black until another load.
- R9: A load strobe while pixels remain is ignored. The current byte finishes unchanged, and no second byte follows.
- R10: While `blankLine` is 1, `rgb` is 0 and neither the pixel position nor the remaining hold count advances. The stream resumes where it stopped.
- R11: A `depthSel` value other than 1, 2 or 4 is treated as 1 bit per pixel.
- R12: Changing `depthSel` or `scaleSel` after a load has no effect on the byte being shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixByte | input | 8 | Display byte to serialize |
| loadStrobe | input | 1 | Request to load `pixByte` |
| depthSel | input | 3 | Bits per pixel: 1, 2 or 4 (others mean 1) |
| scaleSel | input | SCALE_W (3) | Output cycles per pixel (0 means 1) |
| blankLine | input | 1 | Forces black and pauses the serializer |
| rgb | output | 3 | Output colour, bit 0 red, bit 1 green, bit 2 blue |

## Verification
The bench builds each expected colour sequence from the bit-selection rules for every depth. A design that packs the bits of a pixel side by side, or walks the byte from the wrong end, shows wrong colours at depths 2 and 4. Bytes that give indices 8 to 15 catch a palette that does not wrap. Holds of 0, 1, 2 and 4 catch an off-by-one in the hold counter, which stretches or shortens each pixel. Load pulses, depth changes and scale changes in the middle of a stream expose a design that restarts or re-decodes early. A blank window inside a pixel's hold exposes a design that keeps counting while blanked, which would resume late in the stream.

// File: rtl/pix_ser_pkg.sv
package pix_ser_pkg;

  localparam int BYTE_W    = 8;
  localparam int IDX_W     = $clog2(BYTE_W);
  localparam int PAL_DEPTH = 16;
  localparam int PAL_W     = $clog2(PAL_DEPTH);
  localparam int COLOR_W   = 3;
  localparam int DSEL_W    = 3;

  typedef enum logic [1:0] {
    DEPTH_ONE  = 2'd0,
    DEPTH_TWO  = 2'd1,
    DEPTH_FOUR = 2'd2
  } depthMode_t;

  // Control -> datapath strobes
  typedef struct packed {
    logic             loadNow;
    logic             showPix;
    logic [IDX_W-1:0] pixIdx;
  } serStrobe_t;

  // Unsupported depth codes fall back to one bit per pixel (R11)
  function automatic depthMode_t normDepth(input logic [DSEL_W-1:0] code);
    case (code)
      3'd2:    normDepth = DEPTH_TWO;
      3'd4:    normDepth = DEPTH_FOUR;
      default: normDepth = DEPTH_ONE;
    endcase
  endfunction

  // Index of the final pixel in a byte for a depth mode
  function automatic logic [IDX_W-1:0] lastPixel(input depthMode_t mode);
    case (mode)
      DEPTH_TWO:  lastPixel = IDX_W'(BYTE_W / 2 - 1);
      DEPTH_FOUR: lastPixel = IDX_W'(BYTE_W / 4 - 1);
      default:    lastPixel = IDX_W'(BYTE_W - 1);
    endcase
  endfunction

endpackage

// File: rtl/pix_ser_ctrl.sv
module pix_ser_ctrl
  import pix_ser_pkg::*;
#(
  parameter int SCALE_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadStrobe,
  input  logic [DSEL_W-1:0]  depthSel,
  input  logic [SCALE_W-1:0] scaleSel,
  input  logic               blankLine,
  output serStrobe_t         strobes
);

  logic               active;
  logic [IDX_W-1:0]   pixIdx;
  logic [IDX_W-1:0]   lastIdx;
  logic [SCALE_W-1:0] holdCnt;
  logic [SCALE_W-1:0] scaleLat;
  logic [SCALE_W-1:0] scaleEff;
  logic               loadNow;
  logic               running;
  logic               holdDone;

  assign scaleEff = (scaleSel == '0) ? SCALE_W'(1) : scaleSel;
  assign loadNow  = loadStrobe && !active;
  assign running  = active && !blankLine;
  assign holdDone = (holdCnt <= SCALE_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      pixIdx   <= '0;
      lastIdx  <= '0;
      holdCnt  <= '0;
      scaleLat <= '0;
    end else if (loadNow) begin
      active   <= 1'b1;
      pixIdx   <= '0;
      lastIdx  <= lastPixel(normDepth(depthSel));
      holdCnt  <= scaleEff;
      scaleLat <= scaleEff;
    end else if (running) begin
      if (holdDone) begin
        if (pixIdx == lastIdx) begin
          active <= 1'b0;
        end else begin
          pixIdx  <= pixIdx + IDX_W'(1);
          holdCnt <= scaleLat;
        end
      end else begin
        holdCnt <= holdCnt - SCALE_W'(1);
      end
    end
  end

  always_comb begin
    strobes.loadNow = loadNow;
    strobes.showPix = running;
    strobes.pixIdx  = pixIdx;
  end

endmodule

// File: rtl/pix_ser_datapath.sv
module pix_ser_datapath
  import pix_ser_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [BYTE_W-1:0]  pixByte,
  input  logic [DSEL_W-1:0]  depthSel,
  input  serStrobe_t         strobes,
  output logic [COLOR_W-1:0] rgb
);

  logic [BYTE_W-1:0]  byteLat;
  depthMode_t         modeLat;
  logic [BYTE_W-1:0]  aligned;
  logic [PAL_W-1:0]   palIdx;
  logic [COLOR_W-1:0] palTable [PAL_DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteLat <= '0;
      modeLat <= DEPTH_ONE;
    end else if (strobes.loadNow) begin
      byteLat <= pixByte;
      modeLat <= normDepth(depthSel);
    end
  end

  // Shifting left by the pixel number puts bit 7-n at 7, 5-n at 5, ...
  assign aligned = byteLat << strobes.pixIdx;

  always_comb begin
    case (modeLat)
      DEPTH_TWO:  palIdx = {2'b00, aligned[7], aligned[3]};
      DEPTH_FOUR: palIdx = {aligned[7], aligned[5], aligned[3], aligned[1]};
      default:    palIdx = {3'b000, aligned[7]};
    endcase
  end

  // Fixed palette: entry i holds colour i mod 8
  for (genvar g = 0; g < PAL_DEPTH; g++) begin : gen_pal
    assign palTable[g] = COLOR_W'(g % (1 << COLOR_W));
  end

  assign rgb = strobes.showPix ? palTable[palIdx] : '0;

endmodule

// File: rtl/pix_serializer.sv
module pix_serializer
  import pix_ser_pkg::*;
#(
  parameter int SCALE_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [7:0]         pixByte,
  input  logic               loadStrobe,
  input  logic [2:0]         depthSel,
  input  logic [SCALE_W-1:0] scaleSel,
  input  logic               blankLine,
  output logic [2:0]         rgb
);

  serStrobe_t strobes;

  pix_ser_ctrl #(.SCALE_W(SCALE_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .loadStrobe (loadStrobe),
    .depthSel   (depthSel),
    .scaleSel   (scaleSel),
    .blankLine  (blankLine),
    .strobes    (strobes)
  );

  pix_ser_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pixByte  (pixByte),
    .depthSel (depthSel),
    .strobes  (strobes),
    .rgb      (rgb)
  );

endmodule

// File: rtl/pix_serializer_chk.sv
module pix_serializer_chk
  import pix_ser_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic         loadStrobe,
  input logic         blankLine,
  input logic [2:0]   rgb,
  input serStrobe_t   strobes
);

  assert_blank_black_R10: assert property (@(posedge clk) disable iff (!rstN)
    blankLine |-> rgb == 3'd0);

  assert_blank_freeze_R10: assert property (@(posedge clk) disable iff (!rstN)
    (blankLine && !strobes.loadNow) |=> $stable(strobes.pixIdx));

  assert_load_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadNow |=> (strobes.pixIdx == '0) && (strobes.showPix || blankLine));

  assert_busy_keep_R9: assert property (@(posedge clk) disable iff (!rstN)
    (loadStrobe && strobes.showPix) |=> strobes.pixIdx >= $past(strobes.pixIdx));

  assert_index_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadNow |=> (strobes.pixIdx == $past(strobes.pixIdx)) ||
                         (strobes.pixIdx == IDX_W'($past(strobes.pixIdx) + 1'b1)));

endmodule

bind pix_serializer pix_serializer_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .loadStrobe (loadStrobe),
  .blankLine  (blankLine),
  .rgb        (rgb),
  .strobes    (strobes)
);

// File: tb/pix_serializer_bench.sv
module pix_serializer_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] pixByte = '0;
  logic       loadStrobe = 1'b0;
  logic [2:0] depthSel = 3'd1;
  logic [2:0] scaleSel = 3'd1;
  logic       blankLine = 1'b0;
  logic [2:0] rgb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pix_serializer u_pix_serializer (
    .clk(clk), .rstN(rstN), .pixByte(pixByte), .loadStrobe(loadStrobe),
    .depthSel(depthSel), .scaleSel(scaleSel), .blankLine(blankLine), .rgb(rgb)
  );

  task automatic chk(input logic [2:0] act, input logic [2:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rgb got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected palette index from the bit-selection rules (R3, R4, R5, R11)
  function automatic logic [3:0] expIdx(input logic [7:0] b, input int d, input int n);
    if (d == 4) return {b[7-n], b[5-n], b[3-n], b[1-n]};
    if (d == 2) return {2'b00, b[7-n], b[3-n]};
    return {3'b000, b[7-n]};
  endfunction

  // Load a byte, then walk the whole stream with optional blank window and
  // an optional mid-stream poke (depth/scale change, with or without load).
  task automatic runCase(input logic [7:0] b, input logic [2:0] d, input logic [2:0] s,
                         input int blankAt, input int blankLen,
                         input int pokeAt, input bit pokeLoad, input string tag);
    int dEff = (d == 3'd2 || d == 3'd4) ? int'(d) : 1;
    int sEff = (s == 3'd0) ? 1 : int'(s);
    int ppb  = 8 / dEff;
    int total = ppb * sEff + blankLen;
    int outPos = 0;
    pixByte = b; depthSel = d; scaleSel = s; loadStrobe = 1'b1;
    @(posedge clk); #1;
    loadStrobe = 1'b0;
    for (int c = 0; c < total; c++) begin
      logic [2:0] exp;
      blankLine = (c >= blankAt) && (c < blankAt + blankLen);
      if (c == pokeAt) begin
        pixByte    = ~b;
        depthSel   = (dEff == 1) ? 3'd4 : 3'd1;
        scaleSel   = s + 3'd1;
        loadStrobe = pokeLoad;
      end
      if (blankLine) exp = 3'd0;
      else begin
        exp = expIdx(b, dEff, outPos / sEff) % 8;
        outPos++;
      end
      @(negedge clk);
      chk(rgb, exp, tag);
      @(posedge clk); #1;
      loadStrobe = 1'b0;
    end
    blankLine = 1'b0;
    @(negedge clk);
    chk(rgb, 3'd0, {tag, " R8 idle after last pixel"});
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(rgb, 3'd0, "R1 reset black");
    @(posedge clk); #1;
  endtask

  task automatic t_depth1;
    runCase(8'hA5, 3'd1, 3'd1, 99, 0, -1, 1'b0, "R3 R2 1bpp hold1");
    runCase(8'h3C, 3'd1, 3'd2, 99, 0, -1, 1'b0, "R3 R7 1bpp hold2");
  endtask

  task automatic t_depth2;
    runCase(8'hB4, 3'd2, 3'd2, 99, 0, -1, 1'b0, "R4 2bpp hold2");
    runCase(8'h6D, 3'd2, 3'd4, 99, 0, -1, 1'b0, "R4 R7 2bpp hold4");
  endtask

  task automatic t_depth4;
    runCase(8'h8A, 3'd4, 3'd4, 99, 0, -1, 1'b0, "R5 4bpp hold4");
    runCase(8'h57, 3'd4, 3'd1, 99, 0, -1, 1'b0, "R5 4bpp hold1");
  endtask

  task automatic t_palette;
    runCase(8'hFF, 3'd4, 3'd1, 99, 0, -1, 1'b0, "R6 index 15 wraps to 7");
    runCase(8'hAA, 3'd4, 3'd2, 99, 0, -1, 1'b0, "R6 index 15 then 0");
    runCase(8'h01, 3'd4, 3'd1, 99, 0, -1, 1'b0, "R6 red on bit 0");
  endtask

  task automatic t_scaleZero;
    runCase(8'hC3, 3'd1, 3'd0, 99, 0, -1, 1'b0, "R7 scale zero acts as one");
  endtask

  task automatic t_badDepth;
    runCase(8'h96, 3'd3, 3'd1, 99, 0, -1, 1'b0, "R11 depth 3 as 1bpp");
    runCase(8'h2B, 3'd0, 3'd2, 99, 0, -1, 1'b0, "R11 depth 0 as 1bpp");
  endtask

  task automatic t_busyLoad;
    runCase(8'hF0, 3'd1, 3'd1, 99, 0, 3, 1'b1, "R9 load while busy ignored");
    runCase(8'h9C, 3'd2, 3'd2, 99, 0, 7, 1'b1, "R9 load on final cycle ignored");
  endtask

  task automatic t_midChange;
    runCase(8'h5A, 3'd2, 3'd2, 99, 0, 2, 1'b0, "R12 depth and scale change ignored");
  endtask

  task automatic t_blank;
    runCase(8'h96, 3'd2, 3'd2, 3, 3, -1, 1'b0, "R10 blank mid-hold");
    runCase(8'hE1, 3'd4, 3'd4, 0, 2, -1, 1'b0, "R10 blank at start");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_depth1();
    t_depth2();
    t_depth4();
    t_palette();
    t_scaleZero();
    t_badDepth();
    t_busyLoad();
    t_midChange();
    t_blank();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule